// File: doc/BRIEF.md
# Local Interrupt Controller Countdown Timer

This block is the per-processor countdown timer of a local interrupt controller. Software programs a start value, a clock prescale selection and a vector-table entry. The entry selects one-shot or periodic operation, holds a mask bit and holds the 8-bit vector. The counter then steps down once per prescaled tick. When it expires, the block emits a single-cycle interrupt request that carries the vector. Priority resolution and delivery to the core happen further downstream.

Registers are written through a plain write port, one register per cycle, and are read back through a combinational read port. The interrupt output is a valid-only stream: `irq_valid` has no ready partner and cannot be stalled. The consumer must capture `irq_vector` in the one cycle that `irq_valid` is high. An event that is not captured in that cycle is lost.

Register addresses: 0 is the vector-table entry, 1 is the initial count, 2 is the current count (read only), and 3 is the divide configuration.

Top module: `lt_timer`

## Requirements
- R1: After reset, the vector-table entry reads 0x0001_0000 (masked, one-shot, vector 0). The initial count, current count and divide configuration all read 0.
- R2: A write to the divide configuration keeps only data bits 3, 1 and 0. Every other bit of that register reads back as zero.
- R3: The 3-bit divide code is {cfg[3], cfg[1:0]}. The prescale shift is (code + 1) mod 8, so one tick occurs every 2^shift clocks. Code 7 ticks every clock and code 0 ticks every second clock.
- R4: A write to the initial count loads the current count with the written value and clears the prescaler. The first decrement therefore lands 2^shift cycles after the write edge. A write made while a count is running restarts the count from the new value.
- R5: In one-shot mode (entry bit 17 = 0), the count falls by one per tick to zero and then stays at zero. Exactly one interrupt is raised, visible (N+1)·2^shift cycles after the write edge of start value N. A start value of zero raises nothing.
- R6: In periodic mode (entry bit 17 = 1), on the tick where the count is zero the counter reloads the start value and raises an interrupt. Events repeat every (N+1)·2^shift cycles.
- R7: In periodic mode with a start value of zero, the count stays at zero and no interrupt is raised.
- R8: While entry bit 16 (mask) is set, no interrupt is raised, but counting continues. A one-shot expiry that occurs while masked is consumed and is not raised later when the mask is cleared.
- R9: `irq_valid` is high for exactly one cycle per event. While it is high, `irq_vector` equals entry bits 7:0 as they stood at the expiry tick.
- R10: The entry stores only bits 17, 16 and 7:0, and its other bits read as zero. Writes to the current-count address are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with the request |

## Verification
The divide field is exercised with codes 0x0, 0x1, 0x8 and 0xB. The resulting periods of 2, 4, 32 and 1 clocks can only all be right if the split bit mapping and the plus-one wrap are both right. One-shot and periodic runs use different start values, so a reload to the wrong value or an off-by-one period shows up as a shift in event cycle. Zero start values, masked runs and a late unmask separate counting from delivery. A mid-count restart shows whether the initial-count write clears the prescaler phase.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int VEC_W       = 8;
  localparam int SHIFT_W     = 3;
  localparam int PRE_W       = (1 << SHIFT_W) - 1;
  localparam int LVT_PER_BIT = 17;
  localparam int LVT_MSK_BIT = 16;
  localparam int DIV_HI_BIT  = 3;

  typedef enum logic [1:0] {
    REG_LVT  = 2'd0,
    REG_INIT = 2'd1,
    REG_CUR  = 2'd2,
    REG_DIV  = 2'd3
  } lt_reg_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } lt_lvt_t;

  // split code -> prescale shift, wrapping 7 to 0
  function automatic logic [SHIFT_W-1:0] lt_shift(input logic [SHIFT_W-1:0] code);
    return code + {{(SHIFT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/lt_regs.sv
module lt_regs
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic [CNT_W-1:0]  cur_count,
  output lt_lvt_t           lvt_q,
  output logic [CNT_W-1:0]  init_q,
  output logic [SHIFT_W-1:0] div_code,
  output logic              init_wr,
  output logic [DATA_W-1:0] rd_data
);
  assign init_wr = wr_en && (wr_addr == REG_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvt_q.periodic <= 1'b0;
      lvt_q.masked   <= 1'b1;
      lvt_q.vector   <= '0;
      init_q         <= '0;
      div_code       <= '0;
    end else if (wr_en) begin
      case (lt_reg_e'(wr_addr))
        REG_LVT: begin
          lvt_q.periodic <= wr_data[LVT_PER_BIT];
          lvt_q.masked   <= wr_data[LVT_MSK_BIT];
          lvt_q.vector   <= wr_data[VEC_W-1:0];
        end
        REG_INIT: init_q   <= wr_data[CNT_W-1:0];
        REG_DIV:  div_code <= {wr_data[DIV_HI_BIT], wr_data[1:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (lt_reg_e'(rd_addr))
      REG_LVT: begin
        rd_data[LVT_PER_BIT] = lvt_q.periodic;
        rd_data[LVT_MSK_BIT] = lvt_q.masked;
        rd_data[VEC_W-1:0]   = lvt_q.vector;
      end
      REG_INIT: rd_data[CNT_W-1:0] = init_q;
      REG_CUR:  rd_data[CNT_W-1:0] = cur_count;
      REG_DIV: begin
        rd_data[DIV_HI_BIT] = div_code[2];
        rd_data[1:0]        = div_code[1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lt_prescaler.sv
module lt_prescaler
  import lt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam logic [PRE_W-1:0] ONE = {{(PRE_W-1){1'b0}}, 1'b1};

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  // shift of 7 wraps 1<<7 to zero, giving an all-ones mask
  assign mask = (ONE << shift) - ONE;
  assign tick = (pre_q & mask) == mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pre_q <= '0;
    else if (clr) pre_q <= '0;
    else          pre_q <= pre_q + ONE;
  end
endmodule

// File: rtl/lt_counter.sv
module lt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             periodic,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic armed_q;
  logic zero;
  logic fire_ok;

  assign zero    = (cur_q == '0);
  assign fire_ok = periodic ? (reload_val != '0) : armed_q;
  assign expire  = tick && zero && !load && fire_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cur_q   <= load_val;
      armed_q <= (load_val != '0);
    end else if (tick) begin
      if (!zero) begin
        cur_q <= cur_q - ONE;
      end else if (periodic) begin
        cur_q <= reload_val;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lt_timer.sv
module lt_timer
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  lt_lvt_t            lvt_q;
  logic [CNT_W-1:0]   init_q;
  logic [CNT_W-1:0]   cur_count;
  logic [SHIFT_W-1:0] div_code;
  logic               init_wr;
  logic               tick;
  logic               expire;

  lt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .cur_count(cur_count),
    .lvt_q(lvt_q), .init_q(init_q), .div_code(div_code),
    .init_wr(init_wr), .rd_data(rd_data)
  );

  lt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clr(init_wr),
    .shift(lt_shift(div_code)), .tick(tick)
  );

  lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(init_wr),
    .load_val(wr_data[CNT_W-1:0]), .periodic(lvt_q.periodic),
    .reload_val(init_q), .cur_q(cur_count), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= expire && !lvt_q.masked;
      irq_vector <= expire ? lvt_q.vector : '0;
    end
  end
endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk
  import lt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              lvt_masked,
  input logic              lvt_periodic,
  input logic [VEC_W-1:0]  lvt_vector,
  input logic [CNT_W-1:0]  cur_count,
  input logic              init_wr,
  input logic [1:0]        rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid); // R9
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vector == $past(lvt_vector)); // R9
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(lvt_masked)); // R8
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_count) == '0 && !$past(lvt_periodic) && !$past(init_wr)) |-> cur_count == '0); // R5
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cur_count) != '0 && !$past(init_wr)) |->
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - ONE)); // R4
  AST_DIV_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (rd_data[DATA_W-1:4] == '0 && !rd_data[2])); // R2
endmodule

bind lt_timer lt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vector(irq_vector),
  .lvt_masked(lvt_q.masked), .lvt_periodic(lvt_q.periodic),
  .lvt_vector(lvt_q.vector), .cur_count(cur_count), .init_wr(init_wr),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_lt_timer.sv
module sim_lt_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [1:0]  rd_addr;
  logic [31:0] rd_data;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int spur = 0;
  bit done = 1'b0;
  int    exp_t[$];
  int    exp_v[$];
  string exp_tag[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lt_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic pop_exp();
    void'(exp_t.pop_front());
    void'(exp_v.pop_front());
    void'(exp_tag.pop_front());
  endtask

  // monitor: pops the scoreboard as interrupts appear
  always @(negedge clk) begin
    if (rst_n) begin
      while (exp_t.size() > 0 && exp_t[0] < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s missed interrupt actual=none expected=cycle %0d", exp_tag[0], exp_t[0]);
        pop_exp();
      end
      if (irq_valid) begin
        if (exp_t.size() > 0 && exp_t[0] == cyc) begin
          check(irq_vector == exp_v[0][7:0], exp_tag[0], "interrupt vector",
                irq_vector, exp_v[0]);
          pop_exp();
        end else begin
          spur++;
          checks++;
          errors++;
          $display("FAIL R7/R8 unexpected interrupt actual=cycle %0d expected=none", cyc);
        end
      end
    end
  end

  // called in the low phase; the write lands at edge w
  task automatic write_reg(input logic [1:0] a, input logic [31:0] d, output int w);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    w = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int shift_of(input logic [3:0] cfg);
    int code;
    code = {cfg[3], cfg[1:0]};
    return (code + 1) % 8;
  endfunction

  task automatic start_case(input bit per, input bit msk, input logic [3:0] cfg,
                            input int n, input logic [7:0] vec, input int window,
                            input bit push, input string tag, output int w);
    int dummy;
    int step;
    write_reg(2'd3, {28'd0, cfg}, dummy);
    write_reg(2'd1, n, w);
    write_reg(2'd0, (32'(per) << 17) | (32'(msk) << 16) | 32'(vec), dummy);
    step = (n + 1) * (1 << shift_of(cfg));
    if (push && !msk && n != 0) begin
      if (per) begin
        for (int t = w + step; t <= w + window; t += step) begin
          exp_t.push_back(t); exp_v.push_back(vec); exp_tag.push_back(tag);
        end
      end else if (w + step <= w + window) begin
        exp_t.push_back(w + step); exp_v.push_back(vec); exp_tag.push_back(tag);
      end
    end
  endtask

  task automatic end_case(input int w, input int window);
    int dummy;
    wait_until(w + window - 1);
    write_reg(2'd0, 32'h0001_0000, dummy);
  endtask

  initial begin
    logic [31:0] d;
    int w;
    int w2;
    int dummy;
    int s0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(2'd0, d); check(d == 32'h0001_0000, "R1", "reset entry", d, 32'h0001_0000);
    read_reg(2'd1, d); check(d == 0, "R1", "reset initial count", d, 0);
    read_reg(2'd2, d); check(d == 0, "R1", "reset current count", d, 0);
    read_reg(2'd3, d); check(d == 0, "R1", "reset divide", d, 0);

    // R2 divide field bits
    write_reg(2'd3, 32'hFFFF_FFFF, dummy);
    read_reg(2'd3, d); check(d == 32'hB, "R2", "divide readback all ones", d, 32'hB);
    write_reg(2'd3, 32'h4, dummy);
    read_reg(2'd3, d); check(d == 0, "R2", "divide readback bit2", d, 0);

    // R10 entry field bits, current count not writable
    write_reg(2'd2, 32'h55, dummy);
    read_reg(2'd2, d); check(d == 0, "R10", "current count after write", d, 0);
    write_reg(2'd0, 32'hFFFF_FFFF, dummy);
    read_reg(2'd0, d); check(d == 32'h0003_00FF, "R10", "entry readback", d, 32'h0003_00FF);
    write_reg(2'd0, 32'h0001_0000, dummy);

    // one-shot, divide by 1
    start_case(1'b0, 1'b0, 4'hB, 5, 8'h31, 20, 1'b1, "R5", w);
    wait_until(w + 2);
    read_reg(2'd2, d); check(d == 3, "R4", "count two ticks after load", d, 3);
    wait_until(w + 7);
    check(irq_valid == 1'b0, "R9", "pulse length", irq_valid, 0);
    read_reg(2'd2, d); check(d == 0, "R5", "one-shot count rests at zero", d, 0);
    end_case(w, 20);

    // one-shot, divide by 2 (code 0)
    start_case(1'b0, 1'b0, 4'h0, 3, 8'h40, 20, 1'b1, "R3", w);
    read_reg(2'd2, d); check(d == 3, "R4", "no decrement before first tick", d, 3);
    wait_until(w + 2);
    read_reg(2'd2, d); check(d == 2, "R4", "first decrement at 2 cycles", d, 2);
    end_case(w, 20);

    // periodic, divide by 4
    start_case(1'b1, 1'b0, 4'h1, 2, 8'h77, 40, 1'b1, "R6", w);
    wait_until(w + 12);
    read_reg(2'd2, d); check(d == 2, "R6", "reload after expiry", d, 2);
    end_case(w, 40);

    // periodic, divide by 32 (code 4)
    start_case(1'b1, 1'b0, 4'h8, 1, 8'hA5, 140, 1'b1, "R3", w);
    end_case(w, 140);

    // periodic with zero start value
    s0 = spur;
    start_case(1'b1, 1'b0, 4'hB, 0, 8'h11, 50, 1'b1, "R7", w);
    wait_until(w + 49);
    read_reg(2'd2, d); check(d == 0, "R7", "zero periodic count", d, 0);
    check(spur == s0, "R7", "no events for zero periodic", spur - s0, 0);
    end_case(w, 50);

    // masked periodic keeps counting
    s0 = spur;
    start_case(1'b1, 1'b1, 4'hB, 3, 8'h66, 30, 1'b1, "R8", w);
    wait_until(w + 2);
    read_reg(2'd2, d); check(d == 1, "R8", "count runs while masked", d, 1);
    wait_until(w + 28);
    check(spur == s0, "R8", "no events while masked", spur - s0, 0);
    end_case(w, 30);

    // masked one-shot expiry is consumed
    s0 = spur;
    start_case(1'b0, 1'b1, 4'hB, 2, 8'h22, 40, 1'b1, "R8", w);
    wait_until(w + 10);
    write_reg(2'd0, 32'h22, dummy);
    wait_until(w + 30);
    check(spur == s0, "R8", "no late event after unmask", spur - s0, 0);
    end_case(w, 40);

    // restart mid-count
    start_case(1'b0, 1'b0, 4'hB, 10, 8'h5C, 40, 1'b0, "R4", w);
    wait_until(w + 4);
    write_reg(2'd1, 32'd3, w2);
    exp_t.push_back(w2 + 4); exp_v.push_back(8'h5C); exp_tag.push_back("R4");
    wait_until(w2 + 8);
    read_reg(2'd2, d); check(d == 0, "R4", "restarted count at zero", d, 0);
    end_case(w2, 12);

    repeat (5) @(negedge clk);
    check(exp_t.size() == 0, "R5", "all expected events seen", exp_t.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule